// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Sequencer

This block decides when the power switch of a quasi-resonant flyback converter is turned on and off. After each turn-off it waits out a ringing suppression window, then counts the valleys of the drain ringing as falling edges of a synchronous zero-crossing comparator flag. It turns the switch on once the count reaches the valley number requested by the frequency-reduction logic. If the ringing dies out before enough valleys are seen, a maximum off-time timer forces the next turn-on.

During the on phase the current-sense trip flag ends the pulse, but only after a leading-edge blanking window. A maximum on-time timer bounds the pulse whatever the trip flag does. The suppression length is picked by a flag that reports a high auxiliary winding voltage. A hold input, driven by protection or burst logic, keeps the switch off and restarts every timer. All times are whole clock cycles and are set by parameters.

Top module: `qr_valley_seq`

## Requirements
- R1: While the gate is low and suppression has expired, each 1-to-0 transition of `zc_flag` between two consecutive clock samples adds one to `valley_cnt`. The count saturates at VALLEY_MAX (default 7). A counted edge sampled at clock edge k is visible on `valley_cnt` after edge k.
- R2: `valley_cnt` reads 0 in every cycle in which `gate` is high. It is cleared at the same clock edge at which `gate` rises.
- R3: After the gate goes low, no turn-on and no valley counting happen while fewer than SUP_SHORT_CYC cycles have passed if `aux_high` was 1 at the turn-off edge, or fewer than SUP_LONG_CYC cycles if it was 0. The choice holds for the whole off period, so later changes of `aux_high` have no effect. With `valley_req` = 0 the gate is low for exactly SUP+1 cycles.
- R4: Once suppression has expired, the gate rises at the clock edge that follows a cycle in which `valley_cnt` >= `valley_req`. A third counted edge with `valley_req` = 3 raises the gate one edge after the count shows 3.
- R5: A gate that has been low for OFF_MAX_CYC cycles rises regardless of the valley count. Counting starts after a turn-off, a hold release or a reset release.
- R6: `cs_trip` is ignored during the first LEB_CYC cycles of an on period. A trip after that lowers the gate at the next edge, so a steady trip gives a pulse of exactly LEB_CYC+1 cycles.
- R7: The gate never stays high for more than ON_MAX_CYC cycles. With `cs_trip` held at 0 the pulse is exactly ON_MAX_CYC cycles.
- R8: `hold` = 1 sampled at an edge drives the gate low and `valley_cnt` to 0 after that edge and restarts both timers. While held, the suppression choice follows `aux_high` on every edge, and a full suppression window follows the release.
- R9: During reset `gate` is 0 and `valley_cnt` is 0, and the long suppression length is selected. After reset release with `valley_req` = 0 the gate is low for exactly SUP_LONG_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Keeps the switch off and restarts all timers |
| zc_flag | input | 1 | Synchronous zero-crossing comparator output (1 = above threshold) |
| aux_high | input | 1 | Auxiliary voltage above the suppression select level |
| cs_trip | input | 1 | Current-sense comparator trip |
| valley_req | input | VW | Valley number at which to turn on |
| gate | output | 1 | Gate drive for the power switch |
| valley_cnt | output | VW | Valleys counted in the current off period |

## Verification
The bound checker watches on every cycle that the valley count moves only by single steps or back to zero. It also checks that the count is zero when the gate rises, that on and off runs stay within their maximum lengths, that a pulse never ends inside the blanking window unless held, that no turn-on comes before the short suppression time, and that a held cycle is always followed by a low gate. Whether the suppression length follows the level of `aux_high` at turn-off, that edges inside suppression are discarded, and the exact pulse and gap lengths at each limit are shown only by the bench's directed scenarios. A random run then compares every cycle against a model in the bench.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

  // Switching phase of the power switch
  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } qrv_phase_e;

endpackage

// File: rtl/qrv_cycle_timer.sv
// Saturating up counter of cycles spent in one phase.
module qrv_cycle_timer #(
  parameter int LIMIT = 100,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && (cnt_q != LIM)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/qrv_valley_counter.sv
// Detects falling zero-crossing edges and counts valleys.
module qrv_valley_counter #(
  parameter int VMAX = 7,
  parameter int VW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_flag,
  input  logic          count_en,
  input  logic          clr,
  output logic [VW-1:0] cnt
);

  localparam logic [VW-1:0] CAP = VW'(VMAX);

  logic          zc_q;
  logic          fall;
  logic [VW-1:0] cnt_q;
  logic [VW-1:0] cnt_d;

  assign fall = zc_q & ~zc_flag;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (count_en && fall && (cnt_q != CAP)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      zc_q  <= zc_flag;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/qrv_gate_ctrl.sv
// Phase register, suppression select and on/off decisions.
module qrv_gate_ctrl
  import qrv_pkg::*;
#(
  parameter int SUP_SHORT_CYC = 500,
  parameter int SUP_LONG_CYC  = 5000,
  parameter int OFF_MAX_CYC   = 8400,
  parameter int LEB_CYC       = 66,
  parameter int ON_MAX_CYC    = 6000,
  parameter int OFF_W         = 14,
  parameter int ON_W          = 13,
  parameter int VW            = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             aux_high,
  input  logic             cs_trip,
  input  logic [VW-1:0]    valley_req,
  input  logic [VW-1:0]    valley_cnt,
  input  logic [OFF_W-1:0] off_cnt,
  input  logic [ON_W-1:0]  on_cnt,
  output qrv_phase_e       phase,
  output logic             start_on,
  output logic             count_en
);

  localparam logic [OFF_W-1:0] SUP_S    = OFF_W'(SUP_SHORT_CYC);
  localparam logic [OFF_W-1:0] SUP_L    = OFF_W'(SUP_LONG_CYC);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_MAX_CYC - 1);
  localparam logic [ON_W-1:0]  BLANK    = ON_W'(LEB_CYC);
  localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(ON_MAX_CYC - 1);

  qrv_phase_e       phase_q, phase_d;
  logic             sel_long_q, sel_long_d;
  logic [OFF_W-1:0] sup_len;
  logic             supp_done;
  logic             valley_hit;
  logic             off_timeout;
  logic             blank_over;
  logic             on_timeout;
  logic             stop_on;

  always_comb begin
    sup_len     = sel_long_q ? SUP_L : SUP_S;
    supp_done   = (off_cnt >= sup_len);
    valley_hit  = supp_done && (valley_cnt >= valley_req);
    off_timeout = (off_cnt == OFF_LAST);
    blank_over  = (on_cnt >= BLANK);
    on_timeout  = (on_cnt == ON_LAST);

    start_on = (phase_q == PH_OFF) && !hold && (valley_hit || off_timeout);
    stop_on  = (phase_q == PH_ON) &&
               (hold || (blank_over && cs_trip) || on_timeout);
    count_en = (phase_q == PH_OFF) && supp_done && !hold;

    phase_d = phase_q;
    if (start_on) begin
      phase_d = PH_ON;
    end else if (stop_on || hold) begin
      phase_d = PH_OFF;
    end

    sel_long_d = sel_long_q;
    if (hold || stop_on) begin
      sel_long_d = ~aux_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_OFF;
      sel_long_q <= 1'b1;
    end else begin
      phase_q    <= phase_d;
      sel_long_q <= sel_long_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/qr_valley_seq.sv
module qr_valley_seq
  import qrv_pkg::*;
#(
  parameter int SUP_SHORT_CYC = 500,
  parameter int SUP_LONG_CYC  = 5000,
  parameter int OFF_MAX_CYC   = 8400,
  parameter int LEB_CYC       = 66,
  parameter int ON_MAX_CYC    = 6000,
  parameter int VALLEY_MAX    = 7,
  parameter int VW            = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          zc_flag,
  input  logic          aux_high,
  input  logic          cs_trip,
  input  logic [VW-1:0] valley_req,
  output logic          gate,
  output logic [VW-1:0] valley_cnt
);

  localparam int OFF_W = $clog2(OFF_MAX_CYC + 1);
  localparam int ON_W  = $clog2(ON_MAX_CYC + 1);

  qrv_phase_e       phase;
  logic             start_on;
  logic             count_en;
  logic [OFF_W-1:0] off_cnt;
  logic [ON_W-1:0]  on_cnt;
  logic [VW-1:0]    vcnt;
  logic             is_on;

  assign is_on = (phase == PH_ON);

  qrv_cycle_timer #(
    .LIMIT (OFF_MAX_CYC),
    .W     (OFF_W)
  ) u_off_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold | is_on),
    .en    (~is_on),
    .cnt   (off_cnt)
  );

  qrv_cycle_timer #(
    .LIMIT (ON_MAX_CYC),
    .W     (ON_W)
  ) u_on_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hold | ~is_on),
    .en    (is_on),
    .cnt   (on_cnt)
  );

  qrv_valley_counter #(
    .VMAX (VALLEY_MAX),
    .VW   (VW)
  ) u_valley (
    .clk      (clk),
    .rst_n    (rst_n),
    .zc_flag  (zc_flag),
    .count_en (count_en),
    .clr      (hold | start_on | is_on),
    .cnt      (vcnt)
  );

  qrv_gate_ctrl #(
    .SUP_SHORT_CYC (SUP_SHORT_CYC),
    .SUP_LONG_CYC  (SUP_LONG_CYC),
    .OFF_MAX_CYC   (OFF_MAX_CYC),
    .LEB_CYC       (LEB_CYC),
    .ON_MAX_CYC    (ON_MAX_CYC),
    .OFF_W         (OFF_W),
    .ON_W          (ON_W),
    .VW            (VW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .aux_high   (aux_high),
    .cs_trip    (cs_trip),
    .valley_req (valley_req),
    .valley_cnt (vcnt),
    .off_cnt    (off_cnt),
    .on_cnt     (on_cnt),
    .phase      (phase),
    .start_on   (start_on),
    .count_en   (count_en)
  );

  assign gate       = is_on;
  assign valley_cnt = vcnt;

endmodule

// File: rtl/qrv_checker.sv
module qrv_checker #(
  parameter int SUP_SHORT_CYC = 500,
  parameter int OFF_MAX_CYC   = 8400,
  parameter int LEB_CYC       = 66,
  parameter int ON_MAX_CYC    = 6000,
  parameter int VW            = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          gate,
  input logic [VW-1:0] valley_cnt
);

  localparam int OW = $clog2(OFF_MAX_CYC + 2);
  localparam int NW = $clog2(ON_MAX_CYC + 2);

  logic [OW-1:0] off_run;
  logic [NW-1:0] on_run;

  // Cycles the gate has been low since the last high, hold or reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run <= '0;
    end else if (hold || gate) begin
      off_run <= '0;
    end else if (off_run != {OW{1'b1}}) begin
      off_run <= off_run + 1'b1;
    end
  end

  // Cycles the gate has been high in the current pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_run <= '0;
    end else if (!gate) begin
      on_run <= '0;
    end else if (on_run != {NW{1'b1}}) begin
      on_run <= on_run + 1'b1;
    end
  end

  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valley_cnt != $past(valley_cnt)) |->
      ((valley_cnt == VW'($past(valley_cnt) + 1'b1)) || (valley_cnt == '0)));

  a_r2_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (valley_cnt == '0));

  a_r3_no_early_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(off_run) >= OW'(SUP_SHORT_CYC)));

  a_r5_off_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> (off_run < OW'(OFF_MAX_CYC)));

  a_r6_blank_respected: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && !$past(hold)) |-> ($past(on_run) >= NW'(LEB_CYC)));

  a_r7_on_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (on_run < NW'(ON_MAX_CYC)));

  a_r8_hold_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!gate && (valley_cnt == '0)));

endmodule

bind qr_valley_seq qrv_checker #(
  .SUP_SHORT_CYC (SUP_SHORT_CYC),
  .OFF_MAX_CYC   (OFF_MAX_CYC),
  .LEB_CYC       (LEB_CYC),
  .ON_MAX_CYC    (ON_MAX_CYC),
  .VW            (VW)
) u_qrv_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold       (hold),
  .gate       (gate),
  .valley_cnt (valley_cnt)
);

// File: tb/tb_qr_valley_seq.sv
module tb_qr_valley_seq;

  localparam int SUP_S = 8;
  localparam int SUP_L = 40;
  localparam int OFFM  = 100;
  localparam int LEB   = 5;
  localparam int ONM   = 60;
  localparam int VMAX  = 7;
  localparam int VW    = 3;

  logic          clk;
  logic          rst_n;
  logic          hold;
  logic          zc_flag;
  logic          aux_high;
  logic          cs_trip;
  logic [VW-1:0] valley_req;
  logic          gate;
  logic [VW-1:0] valley_cnt;

  int n_chk;
  int n_bad;
  bit cmp_en;

  qr_valley_seq #(
    .SUP_SHORT_CYC (SUP_S),
    .SUP_LONG_CYC  (SUP_L),
    .OFF_MAX_CYC   (OFFM),
    .LEB_CYC       (LEB),
    .ON_MAX_CYC    (ONM),
    .VALLEY_MAX    (VMAX),
    .VW            (VW)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .zc_flag    (zc_flag),
    .aux_high   (aux_high),
    .cs_trip    (cs_trip),
    .valley_req (valley_req),
    .gate       (gate),
    .valley_cnt (valley_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model written from the requirements
  bit m_gate, m_long, m_zcq;
  int m_off, m_on, m_val;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gate <= 1'b0; m_long <= 1'b1; m_zcq <= 1'b0;
      m_off <= 0; m_on <= 0; m_val <= 0;
    end else begin
      int  sup;
      bit  done;
      bit  fall;
      sup  = m_long ? SUP_L : SUP_S;
      done = (m_off >= sup);
      fall = m_zcq && !zc_flag;
      m_zcq <= zc_flag;
      if (hold) begin
        m_gate <= 1'b0; m_off <= 0; m_on <= 0; m_val <= 0;
        m_long <= !aux_high;
      end else if (!m_gate) begin
        m_on <= 0;
        if ((done && m_val >= int'(valley_req)) || m_off == OFFM - 1) begin
          m_gate <= 1'b1; m_val <= 0; m_off <= 0;
        end else begin
          m_off <= m_off + 1;
          if (fall && done && m_val < VMAX) m_val <= m_val + 1;
        end
      end else begin
        m_off <= 0;
        if ((m_on >= LEB && cs_trip) || m_on == ONM - 1) begin
          m_gate <= 1'b0; m_on <= 0; m_long <= !aux_high;
        end else begin
          m_on <= m_on + 1;
        end
      end
    end
  end

  // Every-cycle comparison against the model (R1 R2 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(gate == m_gate, "R4 gate vs model", int'(gate), int'(m_gate));
      check(int'(valley_cnt) == m_val, "R1 valley_cnt vs model", int'(valley_cnt), m_val);
    end
  end

  task automatic hold_then_release(input bit aux);
    @(negedge clk); hold = 1'b1; aux_high = aux;
    @(negedge clk);
    @(negedge clk); hold = 1'b0;
  endtask

  // negedges from now until gate is observed high
  task automatic count_to_high(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!gate && n < 1000);
  endtask

  // negedges the gate stays high, first high observation included
  task automatic count_high(output int n);
    n = 1;
    do begin @(negedge clk); if (gate) n++; end while (gate && n < 1000);
  endtask

  task automatic pulse_zc();
    @(negedge clk); zc_flag = 1'b1;
    @(negedge clk); zc_flag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1bad5eed));
    n_chk = 0; n_bad = 0; cmp_en = 1'b0;
    rst_n = 1'b0; hold = 1'b0; zc_flag = 1'b0; aux_high = 1'b1;
    cs_trip = 1'b1; valley_req = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(gate == 1'b0, "R9 gate in reset", int'(gate), 0);
    check(valley_cnt == '0, "R9 valley in reset", int'(valley_cnt), 0);
    rst_n = 1'b1; cmp_en = 1'b1;
    // R9 long suppression after reset, even with aux_high=1
    count_to_high(n);
    check(n == SUP_L + 1, "R9 low cycles after reset", n, SUP_L + 1);
    // R6 steady trip gives LEB+1 cycles
    count_high(n);
    check(n == LEB + 1, "R6 blanked pulse width", n, LEB + 1);

    // R3 short suppression picked from aux_high during hold
    valley_req = '0;
    hold_then_release(1'b1);
    count_to_high(n);
    check(n == SUP_S + 1, "R3 short suppression", n, SUP_S + 1);
    // R3 turn-off sampled aux_high=1, then it drops: stays short
    @(negedge clk); aux_high = 1'b1;
    while (gate) @(negedge clk);
    aux_high = 1'b0;
    n = 1;
    do begin @(negedge clk); n++; end while (!gate && n < 1000);
    n = n - 1;
    check(n == SUP_S + 1, "R3 choice held at turn-off", n, SUP_S + 1);

    // R3 long suppression discards edges inside it
    cs_trip = 1'b1; valley_req = 3'd1;
    hold_then_release(1'b0);
    pulse_zc(); pulse_zc(); pulse_zc();
    check(valley_cnt == '0, "R3 edges during suppression ignored", int'(valley_cnt), 0);
    repeat (SUP_L) @(negedge clk);
    check(gate == 1'b0, "R3 no turn-on without valley", int'(gate), 0);
    pulse_zc();
    check(valley_cnt == 3'd1, "R1 first counted valley", int'(valley_cnt), 1);
    @(negedge clk);
    check(gate == 1'b1, "R4 turn-on at first valley", int'(gate), 1);

    // R1 R4 R2 third valley with short suppression
    valley_req = 3'd3;
    hold_then_release(1'b1);
    repeat (SUP_S + 2) @(negedge clk);
    pulse_zc(); pulse_zc();
    check(valley_cnt == 3'd2, "R1 two valleys counted", int'(valley_cnt), 2);
    check(gate == 1'b0, "R4 no turn-on below request", int'(gate), 0);
    pulse_zc();
    check(valley_cnt == 3'd3, "R1 third valley counted", int'(valley_cnt), 3);
    @(negedge clk);
    check(gate == 1'b1, "R4 turn-on at third valley", int'(gate), 1);
    check(valley_cnt == '0, "R2 cleared on rise", int'(valley_cnt), 0);

    // R5 maximum off time, R7 maximum on time
    cs_trip = 1'b0; valley_req = 3'd7;
    hold_then_release(1'b1);
    count_to_high(n);
    check(n == OFFM, "R5 max off time", n, OFFM);
    count_high(n);
    check(n == ONM, "R7 max on time", n, ONM);

    // R8 hold during a pulse
    valley_req = '0;
    count_to_high(n);
    @(negedge clk); hold = 1'b1;
    @(negedge clk);
    check(gate == 1'b0, "R8 hold drops gate", int'(gate), 0);
    check(valley_cnt == '0, "R8 hold clears count", int'(valley_cnt), 0);
    hold = 1'b0;

    // Constrained random against the model
    begin
      int hcnt;
      hcnt = 0;
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) zc_flag = ~zc_flag;
        aux_high = 1'($urandom_range(0, 1));
        cs_trip  = ($urandom_range(0, 15) == 0);
        if ((i % 200) == 0) valley_req = VW'($urandom_range(0, 7));
        if (hcnt > 0) begin
          hcnt--;
        end else if ($urandom_range(0, 999) == 0) begin
          hcnt = 3;
        end
        hold = (hcnt > 0);
      end
    end
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule